// File: doc/BRIEF.md
# SONET A1/A2 Word Frame Aligner

This block sits behind a 16-bit deserializer on a SONET/SDH receive path. One word arrives on every clock. The deserializer's word boundary has no fixed relation to the frame, so the 32-bit framing marker (two A1 bytes then two A2 bytes, 0xF6F62828 by default) can start at any of 16 bit positions inside a word. The block holds the last two input words next to the current one. Each cycle it compares all 16 candidate offsets against the marker.

Hunting happens only while the block is enabled and out of frame. When the marker is found, the winning offset is latched. A one-cycle frame pulse is emitted alongside the realigned word it marks, and the block enters the in-frame state. After that, further marker matches are ignored until an out-of-frame strobe re-arms the hunt.

A search flag reports the hunt. It also stays high briefly after a new alignment, long enough to cover the word that carries the third A2 byte.

Top module: `frame_aligner`

## Requirements
- R1: Bit 15 of each input word is the earliest bit on the serial line and bit 0 the latest. A marker whose first bit lies k bit positions after bit 15 of some word (k = 0..15) is found at offset k.
- R2: While enabled and out of frame, the marker is detected in the cycle in which it lies entirely within the two previous words plus the current word and starts inside the oldest of the three.
- R3: Each detection raises the frame pulse for exactly one clock, on the same edge that presents the aligned word holding the second half of the marker (0x2828 by default).
- R4: The output word is registered with one clock of latency. For input word W[n] and latched offset k, it equals bits 31..16 of ({W[n-1], W[n]} shifted left by k). On the detection edge the newly found offset is already used.
- R5: While in frame, marker occurrences produce no pulse and leave the offset unchanged. Driving the out-of-frame input high for one enabled cycle restarts the hunt, and the old offset stays in use until the next detection.
- R6: While the enable input is low, no frame pulse is produced, the offset is held, the out-of-frame input is ignored and the search flag is low unless a post-detection hold is still running.
- R7: The search flag is high whenever a hunt is active (enable high and either out of frame or the out-of-frame input high). It is also high in the frame-pulse cycle and in the cycle after it, and low afterwards while in frame.
- R8: Synchronous reset clears the output word and the frame pulse to 0, selects offset 0 and puts the block out of frame, so that a hunt starts as soon as enable is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Word clock |
| rst | input | 1 | Synchronous active-high reset |
| data_i | input | 16 | Received word, bit 15 earliest on the line |
| fr_en_i | input | 1 | Enables marker hunting |
| oof_i | input | 1 | Out-of-frame strobe, re-arms the hunt |
| data_o | output | 16 | Realigned word |
| frame_o | output | 1 | One-cycle frame pulse marking data_o |
| search_o | output | 1 | Hunt in progress or post-lock hold |

## Verification
The bound checker covers several cycle-level rules on every clock:
- a low enable blocks pulses and freezes the offset;
- a pulse cannot repeat unless re-armed;
- the offset moves only together with a pulse;
- the search flag covers the pulse cycle and the one after it;
- reset clears the outputs.

Only the bench's scenarios can show that the marker is found at each specific offset, in the right cycle, with correctly realigned payload words. The same holds for showing that a locked block ignores fresh markers and that a reset mid-stream restarts the hunt at offset 0.

// File: rtl/fa_pkg.sv
package fa_pkg;

    // Default framing marker: A1 A1 A2 A2, earliest byte in the top bits.
    localparam logic [31:0] FA_MARKER_DEF = 32'hF6F6_2828;
    localparam int          FA_WORD_DEF   = 16;
    localparam int          FA_HOLD_DEF   = 2;

    typedef enum logic {
        FA_HUNT = 1'b0,
        FA_LOCK = 1'b1
    } fa_state_e;

    typedef struct packed {
        logic pulse;
        logic search;
    } fa_flags_t;

    // Number of stored history words needed for a marker of pat_w bits.
    function automatic int hist_words(input int pat_w, input int word_w);
        return pat_w / word_w;
    endfunction

endpackage

// File: rtl/fa_history.sv
module fa_history #(
    parameter int WORD_W = 16,
    parameter int DEPTH  = 2,
    localparam int WIN_W = WORD_W * (DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] word_i,
    output logic [WIN_W-1:0]  win_o
);

    logic [WORD_W-1:0] stage_q [DEPTH];

    assign win_o[WORD_W-1:0] = word_i;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                stage_q[i] <= '0;
            end else if (i == 0) begin
                stage_q[i] <= word_i;
            end else begin
                stage_q[i] <= stage_q[(i == 0) ? 0 : i-1];
            end
        end
        // Older words sit at higher bit positions of the window.
        assign win_o[(i+2)*WORD_W-1 -: WORD_W] = stage_q[i];
    end

endmodule

// File: rtl/fa_matcher.sv
module fa_matcher #(
    parameter int            WORD_W  = 16,
    parameter int            PAT_W   = 32,
    parameter logic [PAT_W-1:0] PATTERN = 32'hF6F6_2828,
    localparam int WIN_W = PAT_W + WORD_W,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [WIN_W-1:0] win_i,
    output logic             hit_o,
    output logic [OFF_W-1:0] off_o
);

    logic [WORD_W-1:0] hit_v;

    // R1: offset k means the marker begins k bits after the oldest word's MSB.
    for (genvar k = 0; k < WORD_W; k++) begin : g_cmp
        assign hit_v[k] = (win_i[WIN_W-1-k -: PAT_W] == PATTERN);
    end

    // Lowest matching offset takes priority.
    always_comb begin
        off_o = '0;
        for (int k = WORD_W-1; k >= 0; k--) begin
            if (hit_v[k]) off_o = OFF_W'(k);
        end
    end

    assign hit_o = |hit_v;

endmodule

// File: rtl/fa_shifter.sv
module fa_shifter #(
    parameter int WORD_W = 16,
    localparam int OFF_W = $clog2(WORD_W)
) (
    input  logic [2*WORD_W-1:0] pair_i,
    input  logic [OFF_W-1:0]    off_i,
    output logic [WORD_W-1:0]   word_o
);

    logic [2*WORD_W-1:0] shifted;

    always_comb begin
        shifted = pair_i << off_i;
        word_o  = shifted[2*WORD_W-1 -: WORD_W];
    end

endmodule

// File: rtl/fa_ctrl.sv
module fa_ctrl
    import fa_pkg::*;
#(
    parameter int OFF_W    = 4,
    parameter int HOLD_CYC = 2,
    localparam int HOLD_W  = $clog2(HOLD_CYC + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_i,
    input  logic             oof_i,
    input  logic             hit_i,
    input  logic [OFF_W-1:0] hit_off_i,
    output logic [OFF_W-1:0] sel_off_o,
    output logic [OFF_W-1:0] align_q_o,
    output fa_flags_t        flags_o
);

    fa_state_e         state_q;
    logic [OFF_W-1:0]  align_q;
    logic [HOLD_W-1:0] hold_q;
    logic              pulse_q;
    logic              hunt;
    logic              take;

    // R5/R6: hunt only when enabled, and either out of frame or re-armed.
    assign hunt = en_i && ((state_q == FA_HUNT) || oof_i);
    assign take = hunt && hit_i;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= FA_HUNT;
            align_q <= '0;
            hold_q  <= '0;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= take;
            if (take) begin
                state_q <= FA_LOCK;
                align_q <= hit_off_i;
                hold_q  <= HOLD_W'(HOLD_CYC);
            end else begin
                if (hunt) state_q <= FA_HUNT;
                if (hold_q != '0) hold_q <= hold_q - HOLD_W'(1);
            end
        end
    end

    assign sel_off_o      = take ? hit_off_i : align_q;
    assign align_q_o      = align_q;
    assign flags_o.pulse  = pulse_q;
    assign flags_o.search = hunt || (hold_q != '0);

endmodule

// File: rtl/frame_aligner.sv
module frame_aligner
    import fa_pkg::*;
#(
    parameter int               WORD_W   = FA_WORD_DEF,
    parameter int               PAT_W    = 32,
    parameter logic [PAT_W-1:0] PATTERN  = FA_MARKER_DEF,
    parameter int               HOLD_CYC = FA_HOLD_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [WORD_W-1:0] data_i,
    input  logic              fr_en_i,
    input  logic              oof_i,
    output logic [WORD_W-1:0] data_o,
    output logic              frame_o,
    output logic              search_o
);

    localparam int OFF_W = $clog2(WORD_W);
    localparam int DEPTH = hist_words(PAT_W, WORD_W);
    localparam int WIN_W = WORD_W * (DEPTH + 1);

    logic [WIN_W-1:0]  win;
    logic              hit;
    logic [OFF_W-1:0]  hit_off;
    logic [OFF_W-1:0]  sel_off;
    logic [OFF_W-1:0]  align_q;
    logic [WORD_W-1:0] aligned;
    logic [WORD_W-1:0] data_q;
    fa_flags_t         flags;

    fa_history #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_hist (
        .clk   (clk),
        .rst   (rst),
        .word_i(data_i),
        .win_o (win)
    );

    fa_matcher #(.WORD_W(WORD_W), .PAT_W(PAT_W), .PATTERN(PATTERN)) u_match (
        .win_i(win),
        .hit_o(hit),
        .off_o(hit_off)
    );

    fa_ctrl #(.OFF_W(OFF_W), .HOLD_CYC(HOLD_CYC)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .en_i     (fr_en_i),
        .oof_i    (oof_i),
        .hit_i    (hit),
        .hit_off_i(hit_off),
        .sel_off_o(sel_off),
        .align_q_o(align_q),
        .flags_o  (flags)
    );

    fa_shifter #(.WORD_W(WORD_W)) u_shift (
        .pair_i(win[2*WORD_W-1:0]),
        .off_i (sel_off),
        .word_o(aligned)
    );

    // R3/R4: data register shares its edge with the pulse register.
    always_ff @(posedge clk) begin
        if (rst) data_q <= '0;
        else     data_q <= aligned;
    end

    assign data_o   = data_q;
    assign frame_o  = flags.pulse;
    assign search_o = flags.search;

endmodule

// File: rtl/fa_checker.sv
module fa_checker #(
    parameter int WORD_W = 16,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              fr_en_i,
    input logic              oof_i,
    input logic              frame_o,
    input logic              search_o,
    input logic [WORD_W-1:0] data_o,
    input logic [OFF_W-1:0]  align_q
);

    p_no_pulse_disabled_r6: assert property (@(posedge clk) disable iff (rst)
        !fr_en_i |=> !frame_o);

    p_offset_frozen_r6: assert property (@(posedge clk) disable iff (rst)
        !fr_en_i |=> $stable(align_q));

    p_single_pulse_r3: assert property (@(posedge clk) disable iff (rst)
        frame_o && !oof_i |=> !frame_o);

    p_offset_moves_with_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && !$stable(align_q) |-> frame_o);

    p_search_on_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        frame_o |-> search_o);

    p_search_tail_r7: assert property (@(posedge clk) disable iff (rst)
        frame_o |=> search_o);

    p_reset_clears_r8: assert property (@(posedge clk)
        rst |=> (!frame_o && data_o == '0 && align_q == '0));

endmodule

bind frame_aligner fa_checker #(.WORD_W(WORD_W), .OFF_W(OFF_W)) u_fa_chk (
    .clk     (clk),
    .rst     (rst),
    .fr_en_i (fr_en_i),
    .oof_i   (oof_i),
    .frame_o (frame_o),
    .search_o(search_o),
    .data_o  (data_o),
    .align_q (align_q)
);

// File: tb/tb_frame_aligner.sv
module tb_frame_aligner;

    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] MARKER = 32'hF6F6_2828;

    logic        clk = 1'b0;
    logic        rst;
    logic [15:0] din;
    logic        fr_en;
    logic        oof;
    logic [15:0] dout;
    logic        frame;
    logic        search;

    always #(CLK_PERIOD/2) clk = ~clk;

    frame_aligner dut (
        .clk     (clk),
        .rst     (rst),
        .data_i  (din),
        .fr_en_i (fr_en),
        .oof_i   (oof),
        .data_o  (dout),
        .frame_o (frame),
        .search_o(search)
    );

    typedef struct {
        logic [15:0] data;
        logic        pulse;
        logic        srch;
        string       req;
    } exp_t;

    exp_t        exp_q[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [15:0] prev_w = '0;
    int          cur_off = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
        end
    endtask

    // R4: output = top half of {previous, current} shifted left by offset.
    function automatic logic [15:0] realign(input logic [15:0] p, input logic [15:0] c,
                                            input int off);
        logic [31:0] t;
        t = {p, c} << off;
        return t[31:16];
    endfunction

    // Monitor: one expected item per driven word, compared after the edge.
    always @(posedge clk) begin
        exp_t e;
        #1;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            check(dout == e.data, e.req, "data", {16'h0, dout}, {16'h0, e.data});
            check(frame == e.pulse, e.req, "frame pulse", {31'h0, frame}, {31'h0, e.pulse});
            check(search == e.srch, e.req, "search", {31'h0, search}, {31'h0, e.srch});
        end
    end

    task automatic drive(input logic [15:0] w, input logic en, input logic o,
                         input logic pulse, input logic srch, input string req);
        exp_t e;
        @(negedge clk);
        din   = w;
        fr_en = en;
        oof   = o;
        e.data  = realign(prev_w, w, cur_off);
        e.pulse = pulse;
        e.srch  = srch;
        e.req   = req;
        exp_q.push_back(e);
        prev_w = w;
    endtask

    // R1/R2: marker placed k bits after the MSB of word 4; detected on word 6.
    task automatic send_stream(input int k, input logic en, input bit hunting,
                               input int oof_word, input string req);
        logic bits [0:207];
        logic [15:0] w;
        logic [15:0] pl;
        bit det;
        for (int i = 0; i < 208; i++) bits[i] = 1'b0;
        for (int i = 0; i < 32; i++) bits[64+k+i] = MARKER[31-i];
        for (int j = 0; j < 6; j++) begin
            pl = 16'h1000 | 16'(j * 3 + k);
            for (int b = 0; b < 16; b++) bits[96+k+16*j+b] = pl[15-b];
        end
        for (int n = 0; n < 13; n++) begin
            for (int b = 0; b < 16; b++) w[15-b] = bits[16*n+b];
            det = hunting && en && (n == 6);
            if (det) cur_off = k;
            drive(w, en, (n == oof_word), det, hunting && en && (n <= 7), req);
        end
    endtask

    task automatic rearm();
        // R5: one enabled cycle of out-of-frame restarts the hunt
        drive(16'h0000, 1'b1, 1'b1, 1'b0, 1'b1, "R5");
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; fr_en = 1'b0; oof = 1'b0; din = '0;
        repeat (3) @(posedge clk);
        #1;
        // R8: reset state
        check(dout == 16'h0, "R8", "reset data", {16'h0, dout}, 32'h0);
        check(frame == 1'b0, "R8", "reset pulse", {31'h0, frame}, 32'h0);
        check(search == 1'b0, "R8", "reset search", {31'h0, search}, 32'h0);
        @(negedge clk);
        rst = 1'b0;

        // R8/R2: out of frame after reset, offset 0 until the first detection
        send_stream(3, 1'b1, 1'b1, -1, "R2");
        // R5: locked block ignores a marker at another offset
        send_stream(10, 1'b1, 1'b0, -1, "R5");
        // R1/R3/R7: hunt at several offsets, including both extremes
        rearm(); send_stream(0, 1'b1, 1'b1, -1, "R1");
        rearm(); send_stream(1, 1'b1, 1'b1, -1, "R3");
        rearm(); send_stream(7, 1'b1, 1'b1, -1, "R7");
        rearm(); send_stream(15, 1'b1, 1'b1, -1, "R4");
        // R6: enable low, out-of-frame strobe ignored, offset 15 kept
        send_stream(5, 1'b0, 1'b0, 2, "R6");

        // R8: reset in the middle of traffic, then a fresh hunt
        @(negedge clk);
        rst = 1'b1; fr_en = 1'b0; oof = 1'b0; din = 16'hFFFF;
        repeat (2) @(posedge clk);
        #1;
        check(dout == 16'h0, "R8", "mid reset data", {16'h0, dout}, 32'h0);
        check(frame == 1'b0, "R8", "mid reset pulse", {31'h0, frame}, 32'h0);
        @(negedge clk);
        rst = 1'b0; din = '0;
        prev_w = '0;
        cur_off = 0;
        send_stream(9, 1'b1, 1'b1, -1, "R8");

        repeat (3) @(posedge clk);
        #2;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule